// File: doc/BRIEF.md
# Supply Lockout Sequencer with Power-Up Hold-Off

This block turns the one-bit output of an external supply comparator into a memory-access lockout. It drives an active-low status pin and an active-high inhibit that goes to the memory control logic. Both outputs leave reset in the locked state. The comparator bit first passes through a synchronizer. A filter then accepts a new level only when several consecutive samples agree.

When the filtered supply turns good, a hold-off counter starts. The lock is released only after the counter has run its full length with the supply good throughout. A filtered drop puts the lock back on at the next clock edge. If the drop comes during the hold-off, the count is discarded, and the next rise starts a fresh full delay.

The host may read the status pin to learn that memory is locked out. The inhibit output gates every array access, so no write can reach the array at low voltage.

Top module: `pwrlock_top`

## Requirements
- R1: While `rstN` is low the outputs are `lockStatN`=0 and `accessBlock`=1. The reset is asynchronous and takes effect without waiting for a clock edge.
- R2: While the filtered supply is bad, `lockStatN` stays 0 and `accessBlock` stays 1.
- R3: Suppose `supplyGood` goes to 1 before clock edge k and then stays 1. `lockStatN` is still 0 after edge k+SYNC_STAGES+FILT_LEN+HOLD_CYCLES and becomes 1 after edge k+SYNC_STAGES+FILT_LEN+HOLD_CYCLES+1.
- R4: Suppose `supplyGood` goes to 0 before edge k while unlocked and then stays 0. `lockStatN` is still 1 after edge k+SYNC_STAGES+FILT_LEN and becomes 0 after edge k+SYNC_STAGES+FILT_LEN+1. The path from a filtered drop to the lock is one clock.
- R5: A filtered drop during the hold-off clears the count. After the next rise the full HOLD_CYCLES delay applies again, measured as in R3.
- R6: The filtered supply changes only after FILT_LEN consecutive synchronized samples of the new level. A `supplyGood` pulse shorter than FILT_LEN cycles changes neither output.
- R7: `accessBlock` is always the inverse of `lockStatN`. `lockStatN`=1 means memory access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| supplyGood | input | 1 | Raw comparator bit, 1 = supply above trip point (asynchronous) |
| lockStatN | output | 1 | Status pin, 0 = locked out, 1 = access allowed |
| accessBlock | output | 1 | Inhibit to memory control, 1 = all array accesses blocked |

## Verification
The bench measures the release edge and the drop edge to the exact cycle. A design that counts one too many or too few hold-off cycles, or adds a register on the falling path, misses by one edge. It drops the supply partway through the hold-off and then raises it again. A design that resumes the old count instead of restarting would release early. It sends pulses one sample shorter than the filter length in both directions, which a filter that accepts too early would pass through. Long random runs of good and bad supply are compared every cycle with a bench model, and an asynchronous reset in the unlocked state must relock the outputs without a clock edge.

// File: rtl/pwrlock_pkg.sv
package pwrlock_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HOLD   = 2'd1,
    LK_OPEN   = 2'd2
  } lockState_t;

  // strobes from control to the hold-off counter
  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } holdStrobe_t;

endpackage

// File: rtl/pwrlock_sync.sv
module pwrlock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= 1'b0;
        else       pipe[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= 1'b0;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/pwrlock_filter.sv
module pwrlock_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleIn,
  output logic filtOut
);

  logic [LEN-1:0] hist;

  if (LEN == 1) begin : gShort
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist <= '0;
      else       hist <= sampleIn;
    end
  end else begin : gLong
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist <= '0;
      else       hist <= {hist[LEN-2:0], sampleIn};
    end
  end

  // accept a level only when every stored sample agrees
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         filtOut <= 1'b0;
    else if (&hist)    filtOut <= 1'b1;
    else if (~|hist)   filtOut <= 1'b0;
  end

endmodule

// File: rtl/pwrlock_datapath.sv
module pwrlock_datapath
  import pwrlock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int HOLD_CYCLES = 64,
  localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyGood,
  input  holdStrobe_t      strobe,
  output logic             supplyOk,
  output logic             holdDone,
  output logic [CNT_W-1:0] holdCnt
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

  logic syncBit;

  pwrlock_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (supplyGood),
    .syncOut (syncBit)
  );

  pwrlock_filter #(.LEN(FILT_LEN)) filt_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (syncBit),
    .filtOut  (supplyOk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobe.cntClear) holdCnt <= '0;
    else if (strobe.cntRun)   holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = (holdCnt == LAST_CNT);

endmodule

// File: rtl/pwrlock_ctrl.sv
module pwrlock_ctrl
  import pwrlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        holdDone,
  output holdStrobe_t strobe,
  output logic        lockStatN,
  output logic        accessBlock
);

  lockState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      LK_LOCKED: if (supplyOk) stateNext = LK_HOLD;
      LK_HOLD: begin
        if (!supplyOk)     stateNext = LK_LOCKED;
        else if (holdDone) stateNext = LK_OPEN;
      end
      LK_OPEN:   if (!supplyOk) stateNext = LK_LOCKED;
      default:   stateNext = LK_LOCKED;
    endcase
  end

  always_comb begin
    strobe.cntClear = !supplyOk || (state != LK_HOLD);
    strobe.cntRun   = (state == LK_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= LK_LOCKED;
      lockStatN   <= 1'b0;
      accessBlock <= 1'b1;
    end else begin
      state       <= stateNext;
      lockStatN   <= (stateNext == LK_OPEN);
      accessBlock <= (stateNext != LK_OPEN);
    end
  end

endmodule

// File: rtl/pwrlock_top.sv
module pwrlock_top
  import pwrlock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int HOLD_CYCLES = 64,
  localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  output logic lockStatN,
  output logic accessBlock
);

  holdStrobe_t      strobe;
  logic             supplyOk;
  logic             holdDone;
  logic [CNT_W-1:0] holdCnt;

  pwrlock_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .strobe     (strobe),
    .supplyOk   (supplyOk),
    .holdDone   (holdDone),
    .holdCnt    (holdCnt)
  );

  pwrlock_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .supplyOk    (supplyOk),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .lockStatN   (lockStatN),
    .accessBlock (accessBlock)
  );

endmodule

// File: rtl/pwrlock_chk.sv
module pwrlock_chk #(
  parameter int HOLD_CYCLES = 64,
  localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             lockStatN,
  input logic             accessBlock,
  input logic             supplyOk,
  input logic             holdDone,
  input logic [CNT_W-1:0] holdCnt
);

  localparam logic [CNT_W:0] RUN_MAX = (CNT_W+1)'(HOLD_CYCLES + 1);

  // consecutive cycles of good filtered supply, saturating
  logic [CNT_W:0] okRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             okRun <= '0;
    else if (!supplyOk)    okRun <= '0;
    else if (okRun != RUN_MAX) okRun <= okRun + 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (!rstN) reset_locked_chk: assert (!lockStatN && accessBlock);
  end

  // R7
  outputs_inverse_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessBlock == !lockStatN);

  // R4
  drop_locks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !lockStatN);

  // R2
  bad_stays_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && !lockStatN) |=> !lockStatN);

  // R3
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatN) |-> $past(holdDone));

  // R3
  release_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatN) |-> (okRun >= (CNT_W+1)'(HOLD_CYCLES)));

  // R5
  drop_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (holdCnt == '0));

endmodule

bind pwrlock_top pwrlock_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .lockStatN   (lockStatN),
  .accessBlock (accessBlock),
  .supplyOk    (supplyOk),
  .holdDone    (holdDone),
  .holdCnt     (holdCnt)
);

// File: tb/pwrlock_top_tb_top.sv
`timescale 1ns/1ps
module pwrlock_top_tb_top;

  localparam int S  = 2;
  localparam int F  = 4;
  localparam int H  = 40;
  localparam int HL = S + F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic lockStatN;
  logic accessBlock;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrlock_top #(.SYNC_STAGES(S), .FILT_LEN(F), .HOLD_CYCLES(H)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .supplyGood  (supplyGood),
    .lockStatN   (lockStatN),
    .accessBlock (accessBlock)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench model built from the requirements
  bit rawHist [HL];
  bit mFilt = 1'b0;
  int mState = 0;  // 0 locked, 1 hold-off, 2 open
  int mCnt = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HL; i++) rawHist[i] = 1'b0;
      mFilt = 1'b0; mState = 0; mCnt = 0;
    end else begin
      bit allHi, allLo;
      case (mState)
        0: begin mCnt = 0; if (mFilt) mState = 1; end
        1: begin
          if (!mFilt) begin mState = 0; mCnt = 0; end
          else if (mCnt == H - 1) begin mState = 2; mCnt = 0; end
          else mCnt++;
        end
        default: if (!mFilt) begin mState = 0; mCnt = 0; end
      endcase
      allHi = 1'b1; allLo = 1'b1;
      for (int i = S; i < S + F; i++) begin
        if (!rawHist[i]) allHi = 1'b0;
        if (rawHist[i])  allLo = 1'b0;
      end
      if (allHi) mFilt = 1'b1;
      else if (allLo) mFilt = 1'b0;
      for (int i = HL - 1; i > 0; i--) rawHist[i] = rawHist[i-1];
      rawHist[0] = supplyGood;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      int expStat;
      expStat = (rstN && mState == 2) ? 1 : 0;
      check(lockStatN == expStat[0], "R3 model status", int'(lockStatN), expStat);
      check(accessBlock == !lockStatN, "R7 inverse", int'(accessBlock), int'(!lockStatN));
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChk++; nBad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: during reset
    #13;
    check(lockStatN == 1'b0, "R1 reset status", int'(lockStatN), 0);
    check(accessBlock == 1'b1, "R1 reset inhibit", int'(accessBlock), 1);
    @(negedge clk); rstN = 1'b1;

    // R2: supply bad for a long time stays locked
    waitEdges(100);
    check(lockStatN == 1'b0, "R2 held low", int'(lockStatN), 0);

    // R3: exact release edge
    supplyGood = 1'b1;
    waitEdges(S + F + H + 1);
    check(lockStatN == 1'b0, "R3 not yet released", int'(lockStatN), 0);
    waitEdges(1);
    check(lockStatN == 1'b1, "R3 released", int'(lockStatN), 1);

    // R6: short low pulse while open is ignored
    waitEdges(10);
    supplyGood = 1'b0;
    waitEdges(F - 1);
    supplyGood = 1'b1;
    waitEdges(S + F + 20);
    check(lockStatN == 1'b1, "R6 low glitch ignored", int'(lockStatN), 1);

    // R4: exact drop edge
    supplyGood = 1'b0;
    waitEdges(S + F + 1);
    check(lockStatN == 1'b1, "R4 not yet dropped", int'(lockStatN), 1);
    waitEdges(1);
    check(lockStatN == 1'b0, "R4 dropped", int'(lockStatN), 0);
    check(accessBlock == 1'b1, "R4 inhibit on", int'(accessBlock), 1);

    // R6: short high pulse while locked does not start hold-off
    waitEdges(10);
    supplyGood = 1'b1;
    waitEdges(F - 1);
    supplyGood = 1'b0;
    waitEdges(S + F + H + 20);
    check(lockStatN == 1'b0, "R6 high glitch ignored", int'(lockStatN), 0);

    // R5: drop mid hold-off, then full delay after next rise
    supplyGood = 1'b1;
    waitEdges(S + F + H / 2);
    supplyGood = 1'b0;
    waitEdges(F + 3);
    check(lockStatN == 1'b0, "R5 locked after mid drop", int'(lockStatN), 0);
    supplyGood = 1'b1;
    waitEdges(S + F + H + 1);
    check(lockStatN == 1'b0, "R5 no early release", int'(lockStatN), 0);
    waitEdges(1);
    check(lockStatN == 1'b1, "R5 full delay release", int'(lockStatN), 1);

    // R1: asynchronous reset while open
    #2 rstN = 1'b0;
    #1;
    check(lockStatN == 1'b0, "R1 async status", int'(lockStatN), 0);
    check(accessBlock == 1'b1, "R1 async inhibit", int'(accessBlock), 1);
    @(negedge clk); rstN = 1'b1;

    // random runs of supply levels, checked by the model
    for (int r = 0; r < 120; r++) begin
      int len;
      len = (($urandom % 4) == 0) ? int'($urandom % F) + 1
                                  : int'($urandom % (H + 20)) + 1;
      supplyGood = ~supplyGood;
      repeat (len) @(negedge clk);
    end
    waitEdges(S + F + H + 5);
    summary();
  end

endmodule